// File: doc/BRIEF.md
# Free-Running Compare Timer

A 16-bit up-counter that advances on a count-clock enable pulse once software sets its run bit. Two compare channels watch the count. Each channel owns a toggle output and a match interrupt. When the count reaches its top value, the next tick returns it to zero and raises an overflow interrupt. The same event sets a sticky overflow flag, which only a software clear removes.

Software reaches the block through a small write port. Address 0 is the control word, with the run bit in bit 0. Addresses 1 and 2 hold the compare values for channels 0 and 1. A write of any data to address 3 clears the overflow flag. The count clock arrives as a one-cycle enable, `tick_i`, in the system clock domain. Starting the timer inverts both toggle outputs at the same moment. A compare value written while the counter runs is used from the next tick on.

Top module: `frt_cmp_timer`

## Requirements
- R1: While the run bit (address 0, bit 0) is 1, the counter increases by one on each clock edge where `tick_i` is 1. On edges where `tick_i` is 0, it keeps its value.
- R2: A write to address 0 with bit 0 set, made while the run bit is 0, inverts both `tgl_o` bits at that write's clock edge. The same write made while the run bit is already 1 leaves the outputs unchanged.
- R3: On a tick while running, if the count equals compare register i, then `irq_match_o[i]` is 1 for the following cycle and `tgl_o[i]` inverts at that edge.
- R4: A tick while running at count FFFFh returns the counter to 0000h and makes `irq_ovf_o` 1 for the following cycle. Counting then continues.
- R5: `ovf_flag_o` becomes 1 with each overflow and stays 1 until a write to address 3, which clears it at that write's edge.
- R6: A compare register written at address 1 (channel 0) or address 2 (channel 1) is used for matching from the next tick after the write cycle. There is no deferred reload.
- R7: A write of 0 to bit 0 of address 0 stops counting and returns the counter to 0000h. Both `tgl_o` bits hold their levels, and no match or overflow interrupt occurs until the next start.
- R8: After reset the counter, both compare registers, both `tgl_o` bits and `ovf_flag_o` are 0.
- R9: If a flag clear write and an overflow fall on the same edge, `ovf_flag_o` ends at 1.
- R10: Each interrupt output is a pulse one system clock wide. It appears only in the cycle after an edge at which `tick_i` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable, one cycle per count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 compare 0, 2 compare 1, 3 flag clear |
| wr_data_i | input | 16 | Register write data |
| tgl_o | output | 2 | Compare toggle outputs, one per channel |
| irq_match_o | output | 2 | Compare match interrupt pulses, one per channel |
| irq_ovf_o | output | 1 | Overflow interrupt pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The count itself is not visible at the ports. A wrong count therefore shows up as a match pulse and a toggle edge on the wrong tick. The error appears on the first tick where the count should equal a compare value, so each test places compare values at known small counts and at FFFFh. A broken stop-clear or missed wrap moves every later match of that run, and the restart and overflow runs catch it on their first expected match. A wrong flag state is visible on `ovf_flag_o` in the cycle right after the overflow or clear edge that went wrong.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int CTRL_ADDR    = 0;
  localparam int CTRL_RUN_BIT = 0;
  // compare channel i sits at address i+1, flag clear after the last channel
  function automatic int cmp_addr(input int ch);
    return ch + 1;
  endfunction
  function automatic int clr_addr(input int num_ch);
    return num_ch + 1;
  endfunction
endpackage

// File: rtl/frt_regs.sv
module frt_regs
  import frt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [CNT_W-1:0]               wr_data_i,
  output logic                           run_o,
  output logic                           start_o,
  output logic                           flag_clr_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_o
);
  logic run_q;
  logic ctrl_wr;
  logic cmp_q [NUM_CH];

  assign ctrl_wr    = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_ADDR));
  assign start_o    = ctrl_wr && wr_data_i[CTRL_RUN_BIT] && !run_q;
  assign flag_clr_o = wr_en_i && (wr_addr_i == ADDR_W'(clr_addr(NUM_CH)));
  assign run_o      = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (ctrl_wr) run_q <= wr_data_i[CTRL_RUN_BIT];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp
    logic [CNT_W-1:0] val_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        val_q <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(cmp_addr(g))))
        val_q <= wr_data_i;
    end
    assign cmp_o[g] = val_q;
  end

  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> run_o) else $error("start did not set run"); // R2
  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wr_data_i[CTRL_RUN_BIT]) |=> !run_o) else $error("stop ignored"); // R7
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic             wrap_o,
  output logic             irq_ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  assign adv_o  = tick_i && run_i;
  assign wrap_o = adv_o && (cnt_q == CNT_MAX);
  assign cnt_o  = cnt_q;
  assign irq_ovf_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= wrap_o;
      if (!run_i)      cnt_q <= '0;
      else if (wrap_o) cnt_q <= '0;
      else if (adv_o)  cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i && cnt_q != CNT_MAX) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1))
    else $error("count step"); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(cnt_q)) else $error("count moved without tick"); // R1
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i && cnt_q == CNT_MAX) |=> (cnt_q == '0 && irq_ovf_o))
    else $error("wrap"); // R4
  AST_STOP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0) else $error("stop clear"); // R7
  AST_OVF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ovf_o |=> !irq_ovf_o) else $error("ovf pulse width"); // R10
endmodule

// File: rtl/frt_cmp_chan.sv
module frt_cmp_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             tgl_o,
  output logic             irq_o
);
  logic hit;
  logic tgl_q;
  logic irq_q;

  assign hit   = adv_i && (cnt_i == cmp_i);
  assign tgl_o = tgl_q;
  assign irq_o = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgl_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= hit;
      if (hit || start_i) tgl_q <= ~tgl_q;
    end
  end

  AST_MATCH_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (irq_o && tgl_o != $past(tgl_o))) else $error("match"); // R3
  AST_START_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> tgl_o != $past(tgl_o)) else $error("start toggle"); // R2
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> !irq_o) else $error("irq without tick"); // R10
  AST_TGL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !start_i) |=> $stable(tgl_o)) else $error("toggle moved"); // R7
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  assign flag_o = flag_q;

  // set has priority over a same-edge clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o) else $error("flag set"); // R9
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o) else $error("flag lost"); // R5
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o) else $error("flag clear"); // R5
endmodule

// File: rtl/frt_cmp_timer.sv
module frt_cmp_timer
  import frt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  localparam int ADDR_W = $clog2(NUM_CH + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [NUM_CH-1:0] tgl_o,
  output logic [NUM_CH-1:0] irq_match_o,
  output logic              irq_ovf_o,
  output logic              ovf_flag_o
);
  logic                         run;
  logic                         start;
  logic                         flag_clr;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]             cnt;
  logic                         adv;
  logic                         wrap;

  frt_regs #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .run_o(run), .start_o(start), .flag_clr_o(flag_clr), .cmp_o(cmp)
  );

  frt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i, .rst_ni, .tick_i, .run_i(run),
    .cnt_o(cnt), .adv_o(adv), .wrap_o(wrap), .irq_ovf_o(irq_ovf_o)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    frt_cmp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni, .adv_i(adv), .start_i(start),
      .cnt_i(cnt), .cmp_i(cmp[g]), .tgl_o(tgl_o[g]), .irq_o(irq_match_o[g])
    );
  end

  frt_ovf_flag u_flag (
    .clk_i, .rst_ni, .set_i(wrap), .clr_i(flag_clr), .flag_o(ovf_flag_o)
  );
endmodule

// File: tb/frt_cmp_timer_bench.sv
module frt_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  tgl, irq_m;
  logic        irq_ovf, flag;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frt_cmp_timer u_frt_cmp_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .tgl_o(tgl),
    .irq_match_o(irq_m), .irq_ovf_o(irq_ovf), .ovf_flag_o(flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  // caller sits at a negedge; n consecutive ticked edges
  task automatic burst(input int n, output int c_ovf, output int c_m0, output int c_m1);
    c_ovf = 0; c_m0 = 0; c_m1 = 0;
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c_ovf += int'(irq_ovf); c_m0 += int'(irq_m[0]); c_m1 += int'(irq_m[1]);
    end
    tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 tgl", tgl, 0);
    chk("R8 irq", {irq_m, irq_ovf}, 0);
    chk("R8 flag", flag, 0);
    wr(2'd0, 16'h1);
    chk("R2 start tgl", tgl, 2'b11);
    tick1(); // count 0 meets reset compare values 0
    chk("R8 cmp reset match", irq_m, 2'b11);
    chk("R3 tgl after match", tgl, 2'b00);
  endtask

  task automatic t_match(); // count now 1
    wr(2'd1, 16'd3); wr(2'd2, 16'd5);
    tick1(); tick1();
    chk("R3 no early match", irq_m, 0);
    tick1(); // count 3
    chk("R3 ch0 match", irq_m, 2'b01);
    chk("R3 ch0 toggle", tgl, 2'b01);
    @(negedge clk);
    chk("R10 pulse width", irq_m, 0);
    repeat (5) @(negedge clk);
    tick1(); // count 4, idle cycles must not advance
    chk("R1 no advance when idle", irq_m, 0);
    tick1(); // count 5
    chk("R3 ch1 match", irq_m, 2'b10);
    chk("R3 ch1 toggle", tgl, 2'b11);
  endtask

  task automatic t_rewrite(); // count now 6
    wr(2'd1, 16'd7);
    tick1();
    chk("R6 no match at 6", irq_m, 0);
    tick1();
    chk("R6 new cmp0 used", irq_m, 2'b01);
    chk("R6 tgl", tgl, 2'b10);
    wr(2'd2, 16'd2); // already passed
    tick1(); // count 8
    chk("R6 passed cmp1 silent", irq_m, 0);
    wr(2'd0, 16'h1);
    chk("R2 rewrite run no toggle", tgl, 2'b10);
  endtask

  task automatic t_stop(); // count now 9
    wr(2'd0, 16'h0);
    chk("R7 tgl held", tgl, 2'b10);
    tick1(); tick1(); tick1();
    chk("R7 no irq when stopped", {irq_m, irq_ovf}, 0);
    chk("R7 tgl still held", tgl, 2'b10);
    wr(2'd1, 16'd1); wr(2'd2, 16'd0);
    wr(2'd0, 16'h1);
    chk("R2 restart tgl", tgl, 2'b01);
    tick1();
    chk("R7 count restarted at 0", irq_m, 2'b10);
    chk("R3 tgl", tgl, 2'b11);
    tick1();
    chk("R7 then count 1", irq_m, 2'b01);
    chk("R3 tgl", tgl, 2'b10);
  endtask

  task automatic t_ovf(); // count now 2
    int co, c0, c1;
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'h0000);
    burst(65533, co, c0, c1); // counts 2..FFFE
    chk("R4 no early ovf", co, 0);
    chk("R3 no early match", c0 + c1, 0);
    chk("R5 flag clear before", flag, 0);
    tick1(); // count FFFF
    chk("R4 ovf pulse", irq_ovf, 1);
    chk("R3 match at top", irq_m, 2'b01);
    chk("R5 flag set", flag, 1);
    chk("R3 tgl", tgl, 2'b11);
    @(negedge clk);
    chk("R10 ovf one cycle", irq_ovf, 0);
    tick1(); // count 0 after wrap
    chk("R4 wrapped to 0", irq_m, 2'b10);
    chk("R4 no second ovf", irq_ovf, 0);
    chk("R5 flag sticky", flag, 1);
    wr(2'd3, 16'h0);
    chk("R5 flag cleared", flag, 0);
  endtask

  task automatic t_collide(); // count now 1
    int co, c0, c1;
    burst(65534, co, c0, c1); // counts 1..FFFE
    chk("R4 no ovf in run", co, 0);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = '0;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    chk("R9 ovf with clear", irq_ovf, 1);
    chk("R9 set wins", flag, 1);
    wr(2'd3, 16'h0);
    chk("R5 clear after", flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_rewrite();
    t_stop();
    t_ovf();
    t_collide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule